// File: doc/BRIEF.md
# Ranked-Preference Weighted Vote Tally

This block keeps the running tally of a ranked-preference election. Each ballot arrives as a one-cycle strobe that carries up to three candidate indices, ordered from first to third preference, with one valid bit per rank. For every candidate the block holds three separate counters: how often it was named first, second and third.

A combinational read port picks one candidate and returns its three counts. It also returns a weighted score computed from those counts and three programmable weights. A ballot that is malformed, or that arrives while the weights are not strictly decreasing, is refused whole. A refused ballot changes no counter and raises a one-cycle error flag. A clear input empties the whole tally in a single cycle.

The block sits behind a front end that captures the voter's button presses and builds the ballot. It also feeds a result display. Both of those are separate blocks.

Top module: `pref_tally`

## Requirements
- R1: While reset is held, and on the cycles that follow it, every count and score on the read port is zero and `err` is low.
- R2: An accepted ballot adds one to the count for rank r of each candidate named in a valid rank r (count 1 = first preference, count 2 = second, count 3 = third). The rank r index sits in `vote_idx[5r+4:5r]`, and its valid bit is `vote_rank_ok[r]`. The new counts are visible on the read port from the clock edge that samples the strobe onward.
- R3: `rd_score` equals count1·`wt_x` + count2·`wt_y` + count3·`wt_z` for the candidate at `rd_idx`, as a 24-bit value. It is computed combinationally from the present weights.
- R4: A strobed ballot that arrives while the weights do not satisfy `wt_x` > `wt_y` > `wt_z` is rejected. `err` is high for the one cycle after the strobe edge, and no count changes.
- R5: A ballot whose valid ranks name the same candidate twice is rejected in the same way as in R4.
- R6: Ranks must be filled from first preference onward. Only `vote_rank_ok` values 3'b001, 3'b011 and 3'b111 are legal. Any other value, including 3'b000, rejects the ballot.
- R7: A valid rank that names an index of 20 or more rejects the ballot. A `rd_idx` of 20 or more reads back zero counts and a zero score.
- R8: `clear` zeroes all 60 counts at the next clock edge. A ballot strobed in the same cycle as `clear` is not counted.
- R9: A count that has reached 16383 stays at 16383 when further votes for it arrive.
- R10: With neither `vote_valid` nor `clear` asserted, no count changes and `err` stays low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clear | input | 1 | Zero the whole tally at the next edge |
| vote_valid | input | 1 | Ballot strobe, one cycle per ballot |
| vote_idx | input | 15 | Three 5-bit candidate indices; rank 0 in the low bits |
| vote_rank_ok | input | 3 | Per-rank valid bits; bit 0 = first preference |
| wt_x | input | 8 | Weight for first preferences |
| wt_y | input | 8 | Weight for second preferences |
| wt_z | input | 8 | Weight for third preferences |
| rd_idx | input | 5 | Candidate selected on the read port |
| rd_cnt1 | output | 14 | First-preference count of the selected candidate |
| rd_cnt2 | output | 14 | Second-preference count of the selected candidate |
| rd_cnt3 | output | 14 | Third-preference count of the selected candidate |
| rd_score | output | 24 | Weighted score of the selected candidate |
| err | output | 1 | High for one cycle after a rejected ballot |

## Verification
On every cycle, the assertions check the following properties. Every ballot that gets accepted met all the validity rules. A rejected ballot leaves every counter untouched and raises the error flag. A clear empties each counter. Without clear, no counter ever moves downward, and no counter moves at all without an increment. Only the bench's scenarios can show the rest. They show that the correct candidate and rank counter advanced, that the score arithmetic matches a model across random weights and counts, that saturation holds at the ceiling, and that out-of-range read indices return zero.

// File: rtl/pref_tally_pkg.sv
package pref_tally_pkg;
  localparam int unsigned TALLY_CAND = 20;
  localparam int unsigned TALLY_RANK = 3;
  localparam int unsigned TALLY_CNT_W = 14;
  localparam int unsigned TALLY_WT_W = 8;
endpackage

// File: rtl/pref_rst_sync.sv
module pref_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];
endmodule

// File: rtl/pref_ballot_check.sv
module pref_ballot_check #(
  parameter int unsigned NUM_CAND = 20,
  parameter int unsigned NUM_RANK = 3,
  parameter int unsigned IDX_W    = 5,
  parameter int unsigned WT_W     = 8
) (
  input  logic                           vote_valid,
  input  logic [NUM_RANK-1:0][IDX_W-1:0] idx_a,
  input  logic [NUM_RANK-1:0]            rank_ok,
  input  logic [NUM_RANK-1:0][WT_W-1:0]  wt_a,
  output logic                           accept
);
  logic mask_ok, wt_ok, range_ok, dup_free;

  always_comb begin
    mask_ok = 1'b0;
    for (int k = 1; k <= NUM_RANK; k++) begin
      if (rank_ok == NUM_RANK'((1 << k) - 1)) mask_ok = 1'b1;
    end
    wt_ok = 1'b1;
    for (int r = 1; r < NUM_RANK; r++) begin
      if (wt_a[r] >= wt_a[r-1]) wt_ok = 1'b0;
    end
    range_ok = 1'b1;
    for (int r = 0; r < NUM_RANK; r++) begin
      if (rank_ok[r] && (int'(idx_a[r]) >= NUM_CAND)) range_ok = 1'b0;
    end
    dup_free = 1'b1;
    for (int a = 0; a < NUM_RANK; a++) begin
      for (int b = a + 1; b < NUM_RANK; b++) begin
        if (rank_ok[a] && rank_ok[b] && (idx_a[a] == idx_a[b])) dup_free = 1'b0;
      end
    end
    accept = vote_valid & mask_ok & wt_ok & range_ok & dup_free;
  end
endmodule

// File: rtl/pref_cand_counter.sv
module pref_cand_counter #(
  parameter int unsigned NUM_RANK = 3,
  parameter int unsigned CNT_W    = 14
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clear,
  input  logic [NUM_RANK-1:0]            inc,
  output logic [NUM_RANK-1:0][CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [NUM_RANK-1:0][CNT_W-1:0] cnt_q, cnt_d;
  logic                           cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = clear | (|inc);
    for (int r = 0; r < NUM_RANK; r++) begin
      if (clear)                          cnt_d[r] = '0;
      else if (inc[r] && cnt_q[r] != CNT_MAX) cnt_d[r] = cnt_q[r] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && inc == '0) |=> $stable(cnt_q));

  for (genvar r = 0; r < NUM_RANK; r++) begin : g_chk
    a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (cnt_q[r] == '0));
    a_r9_no_decrease: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> (cnt_q[r] >= $past(cnt_q[r])));
  end
endmodule

// File: rtl/pref_score.sv
module pref_score #(
  parameter int unsigned NUM_CAND = 20,
  parameter int unsigned NUM_RANK = 3,
  parameter int unsigned IDX_W    = 5,
  parameter int unsigned CNT_W    = 14,
  parameter int unsigned WT_W     = 8,
  parameter int unsigned SCORE_W  = 24
) (
  input  logic [NUM_CAND-1:0][NUM_RANK-1:0][CNT_W-1:0] cnt_all,
  input  logic [IDX_W-1:0]                             rd_idx,
  input  logic [NUM_RANK-1:0][WT_W-1:0]                wt_a,
  output logic [NUM_RANK-1:0][CNT_W-1:0]               rd_cnt,
  output logic [SCORE_W-1:0]                           rd_score
);
  always_comb begin
    rd_cnt = '0;
    for (int c = 0; c < NUM_CAND; c++) begin
      if (rd_idx == IDX_W'(c)) rd_cnt = cnt_all[c];
    end
    rd_score = '0;
    for (int r = 0; r < NUM_RANK; r++) begin
      rd_score = rd_score + SCORE_W'(rd_cnt[r]) * SCORE_W'(wt_a[r]);
    end
  end
endmodule

// File: rtl/pref_tally.sv
module pref_tally
  import pref_tally_pkg::*;
#(
  parameter int unsigned NUM_CAND = TALLY_CAND,
  parameter int unsigned NUM_RANK = TALLY_RANK,
  parameter int unsigned CNT_W    = TALLY_CNT_W,
  parameter int unsigned WT_W     = TALLY_WT_W,
  localparam int unsigned IDX_W   = $clog2(NUM_CAND),
  localparam int unsigned SCORE_W = CNT_W + WT_W + $clog2(NUM_RANK)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear,
  input  logic                      vote_valid,
  input  logic [NUM_RANK*IDX_W-1:0] vote_idx,
  input  logic [NUM_RANK-1:0]       vote_rank_ok,
  input  logic [WT_W-1:0]           wt_x,
  input  logic [WT_W-1:0]           wt_y,
  input  logic [WT_W-1:0]           wt_z,
  input  logic [IDX_W-1:0]          rd_idx,
  output logic [CNT_W-1:0]          rd_cnt1,
  output logic [CNT_W-1:0]          rd_cnt2,
  output logic [CNT_W-1:0]          rd_cnt3,
  output logic [SCORE_W-1:0]        rd_score,
  output logic                      err
);
  logic                                     rst_s_n;
  logic [NUM_RANK-1:0][IDX_W-1:0]           idx_a;
  logic [NUM_RANK-1:0][WT_W-1:0]            wt_a;
  logic                                     accept;
  logic                                     err_d, err_q;
  logic [NUM_CAND-1:0][NUM_RANK-1:0]        inc_all;
  logic [NUM_CAND-1:0][NUM_RANK-1:0][CNT_W-1:0] cnt_all;
  logic [NUM_RANK-1:0][CNT_W-1:0]           rd_cnt;

  assign idx_a = vote_idx;
  assign wt_a  = {wt_z, wt_y, wt_x};

  pref_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n));

  pref_ballot_check #(
    .NUM_CAND(NUM_CAND), .NUM_RANK(NUM_RANK), .IDX_W(IDX_W), .WT_W(WT_W)
  ) u_check (
    .vote_valid(vote_valid), .idx_a(idx_a), .rank_ok(vote_rank_ok),
    .wt_a(wt_a), .accept(accept)
  );

  for (genvar c = 0; c < NUM_CAND; c++) begin : g_cand
    for (genvar r = 0; r < NUM_RANK; r++) begin : g_rank
      assign inc_all[c][r] = accept & vote_rank_ok[r] & (idx_a[r] == IDX_W'(c));
    end
    pref_cand_counter #(.NUM_RANK(NUM_RANK), .CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_s_n), .clear(clear),
      .inc(inc_all[c] & {NUM_RANK{~clear}}), .cnt(cnt_all[c])
    );
  end

  assign err_d = vote_valid & ~accept;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) err_q <= 1'b0;
    else          err_q <= err_d;
  end

  assign err = err_q;

  pref_score #(
    .NUM_CAND(NUM_CAND), .NUM_RANK(NUM_RANK), .IDX_W(IDX_W),
    .CNT_W(CNT_W), .WT_W(WT_W), .SCORE_W(SCORE_W)
  ) u_score (
    .cnt_all(cnt_all), .rd_idx(rd_idx), .wt_a(wt_a),
    .rd_cnt(rd_cnt), .rd_score(rd_score)
  );

  assign rd_cnt1 = rd_cnt[0];
  assign rd_cnt2 = rd_cnt[1];
  assign rd_cnt3 = rd_cnt[2];

  a_r4_accept_weights: assert property (@(posedge clk) disable iff (!rst_s_n)
    accept |-> (wt_x > wt_y && wt_y > wt_z));

  a_r5_accept_distinct: assert property (@(posedge clk) disable iff (!rst_s_n)
    accept |-> !((vote_rank_ok[0] && vote_rank_ok[1] && idx_a[0] == idx_a[1]) ||
                 (vote_rank_ok[0] && vote_rank_ok[2] && idx_a[0] == idx_a[2]) ||
                 (vote_rank_ok[1] && vote_rank_ok[2] && idx_a[1] == idx_a[2])));

  a_r6_accept_contiguous: assert property (@(posedge clk) disable iff (!rst_s_n)
    accept |-> (vote_rank_ok == 3'b001 || vote_rank_ok == 3'b011 || vote_rank_ok == 3'b111));

  a_r4_reject_holds: assert property (@(posedge clk) disable iff (!rst_s_n)
    (vote_valid && !accept && !clear) |=> ($stable(cnt_all) && err));

  a_r10_no_err_idle: assert property (@(posedge clk) disable iff (!rst_s_n)
    !vote_valid |=> !err);
endmodule

// File: tb/sim_pref_tally.sv
`timescale 1ns/1ps
module sim_pref_tally;
  localparam int NC = 20;
  localparam int MAXC = 16383;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        clear, vote_valid;
  logic [14:0] vote_idx;
  logic [2:0]  vote_rank_ok;
  logic [7:0]  wt_x, wt_y, wt_z;
  logic [4:0]  rd_idx;
  logic [13:0] rd_cnt1, rd_cnt2, rd_cnt3;
  logic [23:0] rd_score;
  logic        err;

  int checks = 0;
  int fails  = 0;
  int model [NC][3];

  always #5 clk = ~clk;

  pref_tally u0 (
    .clk(clk), .rst_n(rst_n), .clear(clear), .vote_valid(vote_valid),
    .vote_idx(vote_idx), .vote_rank_ok(vote_rank_ok),
    .wt_x(wt_x), .wt_y(wt_y), .wt_z(wt_z), .rd_idx(rd_idx),
    .rd_cnt1(rd_cnt1), .rd_cnt2(rd_cnt2), .rd_cnt3(rd_cnt3),
    .rd_score(rd_score), .err(err)
  );

  function automatic bit exp_accept(int i0, int i1, int i2, bit [2:0] m,
                                    int x, int y, int z);
    int ix [3];
    ix[0] = i0; ix[1] = i1; ix[2] = i2;
    if (!(m == 3'b001 || m == 3'b011 || m == 3'b111)) return 1'b0;
    if (!(x > y && y > z)) return 1'b0;
    for (int r = 0; r < 3; r++) if (m[r] && ix[r] >= NC) return 1'b0;
    for (int a = 0; a < 3; a++)
      for (int b = a + 1; b < 3; b++)
        if (m[a] && m[b] && ix[a] == ix[b]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int exp_score(int c);
    return model[c][0] * int'(wt_x) + model[c][1] * int'(wt_y) + model[c][2] * int'(wt_z);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    bit ok = 1'b1;
    int bad_c = 0, act = 0, exp = 0;
    for (int c = 0; c < NC; c++) begin
      rd_idx = 5'(c);
      #1;
      if (ok && (int'(rd_cnt1) != model[c][0] || int'(rd_cnt2) != model[c][1] ||
                 int'(rd_cnt3) != model[c][2])) begin
        ok = 1'b0; bad_c = c;
        act = int'(rd_cnt1) * 1000000 + int'(rd_cnt2) * 1000 + int'(rd_cnt3);
        exp = model[c][0] * 1000000 + model[c][1] * 1000 + model[c][2];
      end
    end
    chk(ok, req, $sformatf("counts of candidate %0d", bad_c), act, exp);
    ok = 1'b1;
    for (int c = 0; c < NC; c++) begin
      rd_idx = 5'(c);
      #1;
      if (ok && int'(rd_score) != exp_score(c)) begin
        ok = 1'b0; bad_c = c; act = int'(rd_score); exp = exp_score(c);
      end
    end
    chk(ok, "R3", $sformatf("score of candidate %0d", bad_c), act, exp);
  endtask

  task automatic cast(int i0, int i1, int i2, bit [2:0] m, string req);
    bit acc;
    acc = exp_accept(i0, i1, i2, m, int'(wt_x), int'(wt_y), int'(wt_z));
    @(negedge clk);
    vote_idx = {5'(i2), 5'(i1), 5'(i0)};
    vote_rank_ok = m;
    vote_valid = 1'b1;
    @(negedge clk);
    vote_valid = 1'b0;
    if (acc) begin
      if (m[0]) model[i0][0]++;
      if (m[1]) model[i1][1]++;
      if (m[2]) model[i2][2]++;
    end
    chk(err == !acc, req, "err after ballot", int'(err), int'(!acc));
  endtask

  task automatic model_clear();
    for (int c = 0; c < NC; c++) for (int r = 0; r < 3; r++) model[c][r] = 0;
  endtask

  initial begin
    #1900000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; clear = 1'b0; vote_valid = 1'b0; vote_idx = '0;
    vote_rank_ok = 3'b000; wt_x = 8'd5; wt_y = 8'd3; wt_z = 8'd1; rd_idx = '0;
    model_clear();
    repeat (3) @(negedge clk);
    check_all("R1");
    chk(err == 1'b0, "R1", "err in reset", int'(err), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1");

    // directed accepted ballots
    cast(0, 1, 2, 3'b111, "R2");
    cast(19, 4, 0, 3'b011, "R2");
    cast(7, 0, 0, 3'b001, "R2");
    check_all("R2");

    // weights not strictly decreasing
    wt_x = 8'd4; wt_y = 8'd4; wt_z = 8'd1;
    cast(3, 5, 6, 3'b111, "R4");
    wt_x = 8'd9; wt_y = 8'd2; wt_z = 8'd2;
    cast(3, 5, 6, 3'b111, "R4");
    wt_x = 8'd1; wt_y = 8'd2; wt_z = 8'd3;
    cast(3, 0, 0, 3'b001, "R4");
    wt_x = 8'd200; wt_y = 8'd100; wt_z = 8'd7;
    check_all("R4");

    // duplicates
    cast(5, 5, 1, 3'b111, "R5");
    cast(2, 8, 2, 3'b111, "R5");
    cast(9, 9, 9, 3'b011, "R5");
    cast(9, 1, 9, 3'b011, "R5");   // rank 2 unused: accepted
    check_all("R5");

    // rank masks
    cast(1, 2, 3, 3'b010, "R6");
    cast(1, 2, 3, 3'b101, "R6");
    cast(1, 2, 3, 3'b000, "R6");
    cast(1, 2, 3, 3'b110, "R6");
    check_all("R6");

    // index range
    cast(20, 1, 2, 3'b111, "R7");
    cast(1, 25, 2, 3'b011, "R7");
    cast(1, 2, 31, 3'b001, "R7");  // unused rank may hold anything
    check_all("R7");
    rd_idx = 5'd20; #1;
    chk(rd_cnt1 == 0 && rd_cnt2 == 0 && rd_cnt3 == 0 && rd_score == 0, "R7",
        "read of index 20", int'(rd_score) + int'(rd_cnt1), 0);
    rd_idx = 5'd31; #1;
    chk(rd_score == 0 && rd_cnt1 == 0, "R7", "read of index 31", int'(rd_score), 0);

    // idle cycles
    repeat (5) @(negedge clk);
    chk(err == 1'b0, "R10", "err idle", int'(err), 0);
    check_all("R10");

    // random ballots
    for (int n = 0; n < 400; n++) begin
      int i0, i1, i2, sel;
      bit [2:0] m;
      i0 = int'($urandom_range(0, 21));
      i1 = int'($urandom_range(0, 21));
      i2 = int'($urandom_range(0, 21));
      sel = int'($urandom_range(0, 9));
      m = (sel < 3) ? 3'b111 : (sel < 6) ? 3'b011 : (sel < 8) ? 3'b001 : 3'($urandom_range(0, 7));
      if ($urandom_range(0, 15) == 0) begin
        wt_x = 8'($urandom_range(0, 255));
        wt_y = 8'($urandom_range(0, 255));
        wt_z = 8'($urandom_range(0, 255));
      end else if ($urandom_range(0, 7) == 0) begin
        wt_z = 8'($urandom_range(0, 80));
        wt_y = wt_z + 8'($urandom_range(1, 80));
        wt_x = wt_y + 8'($urandom_range(1, 90));
      end
      cast(i0, i1, i2, m, "R2");
    end
    check_all("R2");
    wt_x = 8'd255; wt_y = 8'd128; wt_z = 8'd1;
    check_all("R3");

    // clear together with a vote
    @(negedge clk);
    clear = 1'b1;
    vote_valid = 1'b1; vote_idx = {5'd2, 5'd1, 5'd0}; vote_rank_ok = 3'b111;
    @(negedge clk);
    clear = 1'b0; vote_valid = 1'b0;
    model_clear();
    chk(err == 1'b0, "R8", "err after clear with valid ballot", int'(err), 0);
    check_all("R8");

    // saturation
    @(negedge clk);
    vote_valid = 1'b1; vote_idx = {5'd0, 5'd0, 5'd7}; vote_rank_ok = 3'b001;
    repeat (MAXC + 6) @(negedge clk);
    vote_valid = 1'b0;
    model[7][0] = MAXC;
    check_all("R9");
    rd_idx = 5'd7; #1;
    chk(int'(rd_score) == MAXC * 255, "R3", "score at full count", int'(rd_score), MAXC * 255);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule